// File: doc/BRIEF.md
# Register-Triggered Byte Copy Engine

This block moves a run of bytes from a source memory space to a destination memory space. A CPU loads a set of small registers over an 8-bit register port: the source offset, a source bank, the destination address, and two control flags. The flags select an external (banked) source and a fixed video data-port destination. Writing a size value to the trigger register starts the copy. The engine then alternates one read cycle with one write cycle until the run is complete.

The run length is twice the written size value, and a size of zero means the largest run of 512 bytes. After every byte the engine writes the advanced source offset back into its own register, so software reading the register after the run sees where the copy stopped. A video destination keeps the same write address for the whole run, because the port behind it steps its own pointer. A normal destination steps by one per byte. A status bit, readable through the register port, shows a run in progress, and a one-clock completion pulse marks its end.

Top module: `bcdma_engine`

## Requirements
- R1: After synchronous active-high reset, busy and done are 0, neither memory strobe is active, and all register offsets read 0x00.
- R2: Writing a nonzero size N to the trigger register produces exactly 2*N memory writes.
- R3: Writing a size of 0 to the trigger register produces exactly 512 memory writes.
- R4: The source offset advances by one per byte and wraps within its 15 bits without touching the bank. After a run the source registers read back the start offset plus the run length, modulo 2^15.
- R5: With the video flag clear, the k-th write of a run (k from 0) goes to the destination address plus k, modulo 2^16. The destination registers still read their programmed value after the run.
- R6: With the video flag set, every write of a run goes to the programmed destination address.
- R7: With the external flag set, the 25-bit read address is {bank[9:0], offset[14:0]}. The bank is formed as {bank-high[1:0], bank-low[7:0]}. With the flag clear, the upper 10 read-address bits are zero.
- R8: Each byte takes a read-strobe cycle followed directly by a write-strobe cycle. The write carries the data the memory returned for that read. The two strobes are never active in the same cycle.
- R9: Busy is 1 from the clock after the trigger write until the last write of the run. While busy, all register writes are ignored, including further trigger writes.
- R10: Done is high for exactly one cycle, namely the cycle after the last write, and busy is 0 in that cycle.
- R11: Register offsets are as follows:
  - 0: source offset bits 7:0
  - 1: source offset bits 14:8, in data bits 6:0
  - 2: destination bits 7:0
  - 3: destination bits 15:8
  - 4: bank bits 7:0
  - 5: bank bits 9:8, in data bits 1:0
  - 6: control, with bit 0 the video flag and bit 1 the external flag
  - 7: writes the size and starts a run, and reads status with bit 0 the busy flag

  Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_rd_en | output | 1 | Memory read strobe; data returns on the next cycle |
| mem_rd_addr | output | 25 | Memory read address |
| mem_rd_data | input | 8 | Memory read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two situations are hard to reach from the ports.

The first is a source offset that crosses 0x7FFF partway through a run with a nonzero bank. The bench produces it by programming the offset two bytes short of the wrap with the external flag set. It then checks, through the data that comes back from its address-keyed memory model, that the bank bits stay constant while the offset wraps.

The second is register traffic that arrives mid-run. The bench issues a second trigger write and an overwrite of the source offset while busy is high. It then confirms that the write count and the final source readback match the first run alone.

// File: rtl/bcdma_pkg.sv
package bcdma_pkg;

    localparam int DATA_W  = 8;
    localparam int OFS_W   = 15;
    localparam int DST_W   = 16;
    localparam int BANK_W  = 10;
    localparam int SIZE_W  = 8;
    localparam int RADDR_W = 3;
    localparam int LEN_W   = SIZE_W + 2;
    localparam int MADDR_W = OFS_W + BANK_W;

    localparam logic [RADDR_W-1:0] REG_SRC_LO  = 3'd0;
    localparam logic [RADDR_W-1:0] REG_SRC_HI  = 3'd1;
    localparam logic [RADDR_W-1:0] REG_DST_LO  = 3'd2;
    localparam logic [RADDR_W-1:0] REG_DST_HI  = 3'd3;
    localparam logic [RADDR_W-1:0] REG_BANK_LO = 3'd4;
    localparam logic [RADDR_W-1:0] REG_BANK_HI = 3'd5;
    localparam logic [RADDR_W-1:0] REG_CTRL    = 3'd6;
    localparam logic [RADDR_W-1:0] REG_TRIG    = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } xfer_state_e;

    typedef struct packed {
        logic [OFS_W-1:0]  src;
        logic [DST_W-1:0]  dst;
        logic [BANK_W-1:0] bank;
        logic              video;
        logic              ext;
    } dma_cfg_t;

    // Byte count: twice the size value, zero selects the largest run
    function automatic logic [LEN_W-1:0] decode_len(input logic [SIZE_W-1:0] sz);
        if (sz == '0)
            return {1'b1, {(SIZE_W + 1){1'b0}}};
        return {1'b0, sz, 1'b0};
    endfunction

    // Read address: bank above the offset for external sources
    function automatic logic [MADDR_W-1:0] compose_addr(input dma_cfg_t c);
        if (c.ext)
            return {c.bank, c.src};
        return {{BANK_W{1'b0}}, c.src};
    endfunction

endpackage

// File: rtl/bcdma_regs.sv
module bcdma_regs
    import bcdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [RADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               busy,
    input  logic               src_wb,
    input  logic [OFS_W-1:0]   src_nxt,
    output dma_cfg_t           cfg,
    output logic               trig,
    output logic [SIZE_W-1:0]  trig_size,
    output logic [DATA_W-1:0]  rdata
);

    localparam int SRC_HI_W  = OFS_W - DATA_W;
    localparam int DST_HI_W  = DST_W - DATA_W;
    localparam int BANK_HI_W = BANK_W - DATA_W;

    logic wr_ok;
    assign wr_ok     = we && !busy;
    assign trig      = wr_ok && (addr == REG_TRIG);
    assign trig_size = wdata[SIZE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (src_wb) begin
            cfg.src <= src_nxt;
        end else if (wr_ok) begin
            case (addr)
                REG_SRC_LO:  cfg.src[DATA_W-1:0]        <= wdata;
                REG_SRC_HI:  cfg.src[OFS_W-1:DATA_W]    <= wdata[SRC_HI_W-1:0];
                REG_DST_LO:  cfg.dst[DATA_W-1:0]        <= wdata;
                REG_DST_HI:  cfg.dst[DST_W-1:DATA_W]    <= wdata[DST_HI_W-1:0];
                REG_BANK_LO: cfg.bank[DATA_W-1:0]       <= wdata;
                REG_BANK_HI: cfg.bank[BANK_W-1:DATA_W]  <= wdata[BANK_HI_W-1:0];
                REG_CTRL: begin
                    cfg.video <= wdata[0];
                    cfg.ext   <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            REG_SRC_LO:  rdata = cfg.src[DATA_W-1:0];
            REG_SRC_HI:  rdata = DATA_W'(cfg.src[OFS_W-1:DATA_W]);
            REG_DST_LO:  rdata = cfg.dst[DATA_W-1:0];
            REG_DST_HI:  rdata = DATA_W'(cfg.dst[DST_W-1:DATA_W]);
            REG_BANK_LO: rdata = cfg.bank[DATA_W-1:0];
            REG_BANK_HI: rdata = DATA_W'(cfg.bank[BANK_W-1:DATA_W]);
            REG_CTRL:    rdata = DATA_W'({cfg.ext, cfg.video});
            default:     rdata = DATA_W'(busy);
        endcase
    end

endmodule

// File: rtl/bcdma_addr_gen.sv
module bcdma_addr_gen
    import bcdma_pkg::*;
(
    input  dma_cfg_t           cfg,
    output logic [MADDR_W-1:0] rd_addr,
    output logic [OFS_W-1:0]   src_nxt
);

    assign rd_addr = compose_addr(cfg);
    // Offset wraps inside its own width; bank is never carried into
    assign src_nxt = cfg.src + OFS_W'(1);

endmodule

// File: rtl/bcdma_fsm.sv
module bcdma_fsm
    import bcdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [SIZE_W-1:0] trig_size,
    input  dma_cfg_t          cfg,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic              wr_en,
    output logic [DST_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              src_wb,
    output logic              busy,
    output logic              done
);

    xfer_state_e          state;
    logic [LEN_W-1:0]     remain;
    logic [DST_W-1:0]     dst_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            remain  <= '0;
            dst_cur <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (trig) begin
                        remain  <= decode_len(trig_size);
                        dst_cur <= cfg.dst;
                        state   <= ST_READ;
                    end
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    if (!cfg.video)
                        dst_cur <= dst_cur + DST_W'(1);
                    remain <= remain - LEN_W'(1);
                    if (remain == LEN_W'(1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_en   = (state == ST_READ);
    assign wr_en   = (state == ST_WRITE);
    assign src_wb  = wr_en;
    assign wr_addr = dst_cur;
    assign wr_data = rd_data;
    assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/bcdma_engine.sv
module bcdma_engine
    import bcdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               mem_rd_en,
    output logic [MADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               mem_wr_en,
    output logic [DST_W-1:0]   mem_wr_addr,
    output logic [DATA_W-1:0]  mem_wr_data,
    output logic               busy,
    output logic               done
);

    dma_cfg_t          cfg;
    logic              trig;
    logic [SIZE_W-1:0] trig_size;
    logic              src_wb;
    logic [OFS_W-1:0]  src_nxt;

    bcdma_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .src_wb    (src_wb),
        .src_nxt   (src_nxt),
        .cfg       (cfg),
        .trig      (trig),
        .trig_size (trig_size),
        .rdata     (reg_rdata)
    );

    bcdma_addr_gen u_addr (
        .cfg     (cfg),
        .rd_addr (mem_rd_addr),
        .src_nxt (src_nxt)
    );

    bcdma_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .trig_size (trig_size),
        .cfg       (cfg),
        .rd_data   (mem_rd_data),
        .rd_en     (mem_rd_en),
        .wr_en     (mem_wr_en),
        .wr_addr   (mem_wr_addr),
        .wr_data   (mem_wr_data),
        .src_wb    (src_wb),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: rtl/bcdma_checker.sv
module bcdma_checker
    import bcdma_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mem_rd_en,
    input logic               mem_wr_en,
    input logic [MADDR_W-1:0] mem_rd_addr,
    input logic               busy,
    input logic               done
);

    AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en)); // R8

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(mem_rd_en)); // R8

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> mem_wr_en); // R8

    AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en || mem_wr_en) |-> busy); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_wr_en) && !busy)); // R10

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_wr_en) && $past(mem_rd_en, 2)) |->
        (mem_rd_addr == {$past(mem_rd_addr[MADDR_W-1:OFS_W], 2),
                         $past(mem_rd_addr[OFS_W-1:0], 2) + OFS_W'(1)})); // R4

endmodule

bind bcdma_engine bcdma_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_rd_addr (mem_rd_addr),
    .busy        (busy),
    .done        (done)
);

// File: tb/bcdma_engine_test.sv
module bcdma_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_rd_en;
    logic [24:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        mem_wr_en;
    logic [15:0] mem_wr_addr;
    logic [7:0]  mem_wr_data;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_seen  = 0;
    logic prev_rd = 1'b0;
    logic prev_wr = 1'b0;
    logic [23:0] exp_q[$];

    always #5 clk = ~clk;

    bcdma_engine uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] mem_fn(input logic [24:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ {a[24], 7'b0} ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: synchronous read, data one cycle after the strobe
    always @(posedge clk)
        if (mem_rd_en) mem_rd_data <= mem_fn(mem_rd_addr);

    // Monitor: pops the scoreboard on every write
    always @(negedge clk) begin
        if (!rst) begin
            chk(!(mem_rd_en && mem_wr_en), "R8 strobe overlap", {mem_rd_en, mem_wr_en}, 0);
            if (mem_wr_en) begin
                logic [23:0] item;
                wr_seen++;
                chk(prev_rd, "R8 write follows read", prev_rd, 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R2 extra write", mem_wr_addr, 0);
                end else begin
                    item = exp_q.pop_front();
                    chk(mem_wr_addr == item[23:8], "R5/R6 write address", mem_wr_addr, item[23:8]);
                    chk(mem_wr_data == item[7:0], "R7/R8 write data", mem_wr_data, item[7:0]);
                end
            end
            if (done)
                chk(!busy && prev_wr, "R10 done timing", {busy, prev_wr}, 1);
            if (prev_wr && !mem_rd_en && !done && !busy)
                chk(0, "R10 missing done", 0, 1);
        end
        prev_rd = mem_rd_en;
        prev_wr = mem_wr_en;
    end

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setup(input logic [14:0] src, input logic [15:0] dst, input logic [9:0] bank,
                         input bit ext, input bit video, input logic [7:0] size, output int len);
        reg_write(3'd0, src[7:0]);
        reg_write(3'd1, {1'b0, src[14:8]});
        reg_write(3'd2, dst[7:0]);
        reg_write(3'd3, dst[15:8]);
        reg_write(3'd4, bank[7:0]);
        reg_write(3'd5, {6'b0, bank[9:8]});
        reg_write(3'd6, {6'b0, ext, video});
        len = (size == 0) ? 512 : 2 * size;
        for (int i = 0; i < len; i++) begin
            logic [14:0] s;
            logic [24:0] a;
            logic [15:0] w;
            s = src + 15'(i);
            a = ext ? {bank, s} : {10'b0, s};
            w = video ? dst : dst + 16'(i);
            exp_q.push_back({w, mem_fn(a)});
        end
        wr_seen = 0;
        reg_write(3'd7, size);
    endtask

    task automatic finish_run(input string tag, input logic [14:0] src, input logic [15:0] dst, input int len);
        logic [7:0] lo, hi;
        logic [14:0] s_exp;
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(done, {tag, " done seen"}, done, 1);
        chk(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
        chk(wr_seen == len, {tag, " write count"}, wr_seen, len);
        exp_q.delete();
        s_exp = src + 15'(len);
        reg_read(3'd0, lo);
        reg_read(3'd1, hi);
        chk({hi[6:0], lo} == s_exp, "R4 source readback", {hi, lo}, s_exp);
        reg_read(3'd2, lo);
        reg_read(3'd3, hi);
        chk({hi, lo} == dst, "R5 destination unchanged", {hi, lo}, dst);
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int len;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1 outputs idle",
            {busy, done, mem_rd_en, mem_wr_en}, 0);
        for (int r = 0; r < 8; r++) begin
            reg_read(3'(r), d);
            chk(d == 8'h00, "R1 register zero", d, 0);
        end

        // R11: register map readback
        reg_write(3'd1, 8'hFF);
        reg_read(3'd1, d);  chk(d == 8'h7F, "R11 source high width", d, 8'h7F);
        reg_write(3'd5, 8'hFF);
        reg_read(3'd5, d);  chk(d == 8'h03, "R11 bank high width", d, 8'h03);
        reg_write(3'd6, 8'hFE);
        reg_read(3'd6, d);  chk(d == 8'h02, "R11 control bits", d, 8'h02);
        reg_write(3'd3, 8'hC3);
        reg_read(3'd3, d);  chk(d == 8'hC3, "R11 destination high", d, 8'hC3);

        // R2, R5: internal source, stepping destination
        setup(15'h0123, 16'h4000, 10'h155, 1'b0, 1'b0, 8'd3, len);
        finish_run("R2", 15'h0123, 16'h4000, len);

        // R2 boundary: size 1
        setup(15'h0010, 16'h0020, 10'h000, 1'b0, 1'b0, 8'd1, len);
        finish_run("R2 size1", 15'h0010, 16'h0020, len);

        // R6: video destination holds the address
        setup(15'h1000, 16'h2007, 10'h000, 1'b0, 1'b1, 8'd4, len);
        finish_run("R6", 15'h1000, 16'h2007, len);

        // R7, R4: external bank, offset wraps without touching the bank
        setup(15'h7FFE, 16'h0100, 10'h2A5, 1'b1, 1'b0, 8'd2, len);
        finish_run("R7 wrap", 15'h7FFE, 16'h0100, len);

        // R3: size zero means 512, destination wraps at 16 bits
        setup(15'h0200, 16'hFF00, 10'h3FF, 1'b1, 1'b0, 8'd0, len);
        finish_run("R3", 15'h0200, 16'hFF00, len);

        // R9: writes during a run are ignored
        setup(15'h0400, 16'h0800, 10'h001, 1'b0, 1'b0, 8'd8, len);
        chk(busy, "R9 busy after trigger", busy, 1);
        reg_read(3'd7, d);
        chk(d == 8'h01, "R9 status busy bit", d, 8'h01);
        reg_write(3'd7, 8'h05);
        reg_write(3'd0, 8'hAA);
        reg_write(3'd6, 8'h01);
        finish_run("R9", 15'h0400, 16'h0800, len);
        reg_read(3'd6, d);
        chk(d == 8'h00, "R9 control unchanged", d, 8'h00);
        reg_read(3'd7, d);
        chk(d == 8'h00, "R9 status idle", d, 8'h00);
        repeat (4) @(negedge clk);
        chk(!busy && wr_seen == len, "R9 no second run", wr_seen, len);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule